// File: doc/BRIEF.md
# Stream-Fed Burst Write Master

This block turns block-transfer commands into memory-mapped burst writes. A command gives a byte start address and a byte length. The data to be written comes from a separate valid/ready input stream, one word per beat. The block buffers incoming words in a small queue. It splits each block into bursts of at most `MAX_BURST` words. A burst is started only once every word it needs is already buffered, so a burst never pauses halfway for lack of data.

When realignment is enabled and the start address is not on a burst boundary, the first burst is cut short so that every later burst begins on a boundary. The last burst is trimmed to the words that remain. The command input stays not-ready while a block is in progress. It becomes ready again in the cycle after the final beat of the block has been accepted by memory.

Top module: `burst_write_master`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cmdReady` is 1, `dataReady` is 1 and `memWrite` is 0.
- R2: A command is taken in a cycle where `cmdValid` and `cmdReady` are both 1. For a nonzero length, `cmdReady` stays 0 until the last beat of that block is accepted, and is 1 in the cycle right after that beat.
- R3: A command with byte address A and byte length L produces exactly L/4 accepted beats. They go to word addresses A/4, A/4+1, ... in increasing order, and carry the input stream words in arrival order. Beat k of a burst targets word `memAddr/4 + k`.
- R4: `memBurstCount` lies between 1 and `MAX_BURST` (default 2) while `memWrite` is 1. `memAddr` holds the first address of the burst for all of its beats. No burst crosses a `MAX_BURST`-word boundary.
- R5: When the start word address W is not a multiple of `MAX_BURST`, the first burst has length min(remaining words, `MAX_BURST` − W mod `MAX_BURST`).
- R6: Every burst after the first has length min(remaining words, `MAX_BURST`), so only the final burst can be short.
- R7: A burst starts only when the buffer holds at least `memBurstCount` words. Once started, `memWrite` stays 1 until all of its beats are accepted.
- R8: While `memWrite` and `memWaitRequest` are both 1, the next cycle keeps `memWrite` at 1 with `memAddr`, `memBurstCount` and `memWriteData` unchanged.
- R9: `dataReady` is 1 exactly when fewer than `FIFO_DEPTH` (default 4) words are buffered. A word is taken when `dataValid` and `dataReady` are both 1.
- R10: A command of length 0 is taken without any write. `cmdReady` is 1 and `memWrite` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command can be taken |
| cmdAddr | input | ADDR_W | Byte start address, word aligned |
| cmdLen | input | LEN_W | Byte length, multiple of the word size |
| dataValid | input | 1 | Input word present |
| dataReady | output | 1 | Input word can be taken |
| dataIn | input | DATA_W | Input word |
| memWrite | output | 1 | Write request |
| memAddr | output | ADDR_W | Byte address of the burst's first word |
| memBurstCount | output | $clog2(MAX_BURST+1) | Words in the current burst |
| memWriteData | output | DATA_W | Word for the current beat |
| memWaitRequest | input | 1 | Memory stall; current beat is held |

## Verification
The word queue can take a stream word and hand a word to an accepted memory beat in the same cycle. The count must then stay the same while both pointers move. The bench provokes this by keeping `dataValid` high or randomly toggled while `memWaitRequest` is driven never, half the time, or three quarters of the time. It judges the result by checking every accepted beat's address and data against arithmetic sequences, and by checking `dataReady` every cycle against a model of the word count.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BURST
  } bwmState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic startBurst;
    logic beat;
    logic inBurst;
  } bwmCtrl_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic cmdZero;
    logic haveBurst;
    logic lastBeat;
    logic finalBurst;
  } bwmStat_t;

endpackage

// File: rtl/bwm_datapath.sv
module bwm_datapath
  import bwm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MAX_BURST  = 2,
  parameter int FIFO_DEPTH = 4,
  parameter bit REALIGN    = 1'b1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  bwmCtrl_t                       ctrl,
  output bwmStat_t                       stat,
  input  logic [ADDR_W-1:0]              cmdAddr,
  input  logic [LEN_W-1:0]               cmdLen,
  input  logic                           dataValid,
  output logic                           dataReady,
  input  logic [DATA_W-1:0]              dataIn,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [$clog2(MAX_BURST+1)-1:0] memBurstCount,
  output logic [DATA_W-1:0]              memWriteData,
  input  logic                           memWaitRequest
);

  localparam int BYTES   = DATA_W / 8;
  localparam int BYTE_SH = $clog2(BYTES);
  localparam int WADDR_W = ADDR_W - BYTE_SH;
  localparam int WLEN_W  = LEN_W - BYTE_SH;
  localparam int BC_W    = $clog2(MAX_BURST + 1);
  localparam int PTR_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int OFF_W   = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

  // ---------------- word queue ----------------
  logic [DATA_W-1:0] store [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              push, pop;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(FIFO_DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign dataReady = (count < CNT_W'(FIFO_DEPTH));
  assign push      = dataValid && dataReady;
  assign pop       = ctrl.beat;

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bumpPtr(wrPtr);
      if (pop)  rdPtr <= bumpPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign memWriteData = store[rdPtr];

  // ---------------- block and burst tracking ----------------
  logic [WADDR_W-1:0] cmdWord, curWord, burstWord;
  logic [WLEN_W-1:0]  cmdWords, remWords;
  logic [BC_W-1:0]    room, nextLen, burstLen, beatsLeft;

  assign cmdWord  = WADDR_W'(cmdAddr >> BYTE_SH);
  assign cmdWords = WLEN_W'(cmdLen >> BYTE_SH);

  generate
    if (REALIGN && MAX_BURST > 1) begin : g_align
      logic [OFF_W-1:0] offset;
      assign offset = curWord[OFF_W-1:0];
      assign room   = BC_W'(MAX_BURST) - BC_W'(offset);

      // R4
      no_cross_chk: assert property (@(posedge clk) disable iff (!rstN)
        ctrl.inBurst |-> (int'(burstWord[OFF_W-1:0]) + int'(burstLen) <= MAX_BURST));
    end else begin : g_flat
      assign room = BC_W'(MAX_BURST);
    end
  endgenerate

  assign nextLen = (remWords < WLEN_W'(room)) ? BC_W'(remWords) : room;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWord   <= '0;
      remWords  <= '0;
      burstWord <= '0;
      burstLen  <= '0;
      beatsLeft <= '0;
    end else begin
      if (ctrl.loadCmd) begin
        curWord  <= cmdWord;
        remWords <= cmdWords;
      end
      if (ctrl.startBurst) begin
        burstWord <= curWord;
        burstLen  <= nextLen;
        beatsLeft <= nextLen;
      end
      if (ctrl.beat) begin
        beatsLeft <= beatsLeft - 1'b1;
        if (beatsLeft == BC_W'(1)) begin
          curWord  <= curWord + WADDR_W'(burstLen);
          remWords <= remWords - WLEN_W'(burstLen);
        end
      end
    end
  end

  assign stat.cmdZero    = (cmdWords == '0);
  assign stat.haveBurst  = (count >= CNT_W'(nextLen));
  assign stat.lastBeat   = (beatsLeft == BC_W'(1));
  assign stat.finalBurst = (remWords == WLEN_W'(burstLen));

  assign memAddr       = ADDR_W'(burstWord) << BYTE_SH;
  assign memBurstCount = burstLen;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(FIFO_DEPTH));

  // R7
  beat_has_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.beat |-> (count != '0));

  // R8
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.inBurst && memWaitRequest) |=>
      ($stable(memWriteData) && $stable(memAddr) && $stable(memBurstCount)));

endmodule

// File: rtl/bwm_control.sv
module bwm_control
  import bwm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  output logic     cmdReady,
  input  logic     memWaitRequest,
  output logic     memWrite,
  input  bwmStat_t stat,
  output bwmCtrl_t ctrl
);

  bwmState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctrl      = '0;
    cmdReady  = (state == ST_IDLE);
    memWrite  = (state == ST_BURST);
    ctrl.inBurst = memWrite;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          ctrl.loadCmd = 1'b1;
          nextState    = stat.cmdZero ? ST_IDLE : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (stat.haveBurst) begin
          ctrl.startBurst = 1'b1;
          nextState       = ST_BURST;
        end
      end
      ST_BURST: begin
        if (!memWaitRequest) begin
          ctrl.beat = 1'b1;
          if (stat.lastBeat) nextState = stat.finalBurst ? ST_IDLE : ST_WAIT;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R2
  busy_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadCmd && !stat.cmdZero) |=> !cmdReady);

  // R10
  zero_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadCmd && stat.cmdZero) |=> (cmdReady && !memWrite));

  // R8
  hold_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && memWaitRequest) |=> memWrite);

  // R7
  no_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && !stat.lastBeat) |=> memWrite);

endmodule

// File: rtl/burst_write_master.sv
module burst_write_master
  import bwm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MAX_BURST  = 2,
  parameter int FIFO_DEPTH = 4,
  parameter bit REALIGN    = 1'b1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cmdValid,
  output logic                           cmdReady,
  input  logic [ADDR_W-1:0]              cmdAddr,
  input  logic [LEN_W-1:0]               cmdLen,
  input  logic                           dataValid,
  output logic                           dataReady,
  input  logic [DATA_W-1:0]              dataIn,
  output logic                           memWrite,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [$clog2(MAX_BURST+1)-1:0] memBurstCount,
  output logic [DATA_W-1:0]              memWriteData,
  input  logic                           memWaitRequest
);

  bwmCtrl_t ctrl;
  bwmStat_t stat;

  bwm_control u_control (
    .clk            (clk),
    .rstN           (rstN),
    .cmdValid       (cmdValid),
    .cmdReady       (cmdReady),
    .memWaitRequest (memWaitRequest),
    .memWrite       (memWrite),
    .stat           (stat),
    .ctrl           (ctrl)
  );

  bwm_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LEN_W      (LEN_W),
    .MAX_BURST  (MAX_BURST),
    .FIFO_DEPTH (FIFO_DEPTH),
    .REALIGN    (REALIGN)
  ) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .ctrl           (ctrl),
    .stat           (stat),
    .cmdAddr        (cmdAddr),
    .cmdLen         (cmdLen),
    .dataValid      (dataValid),
    .dataReady      (dataReady),
    .dataIn         (dataIn),
    .memAddr        (memAddr),
    .memBurstCount  (memBurstCount),
    .memWriteData   (memWriteData),
    .memWaitRequest (memWaitRequest)
  );

  // R4
  burst_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (memBurstCount != '0 && int'(memBurstCount) <= MAX_BURST));

endmodule

// File: tb/burst_write_master_tb.sv
module burst_write_master_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LW = 16;
  localparam int MB = 2;
  localparam int FD = 4;
  localparam int BY = DW / 8;
  localparam int BCW = $clog2(MB + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic           cmdValid = 1'b0, cmdReady;
  logic [AW-1:0]  cmdAddr = '0;
  logic [LW-1:0]  cmdLen = '0;
  logic           dataValid = 1'b0, dataReady;
  logic [DW-1:0]  dataIn = '0;
  logic           memWrite;
  logic [AW-1:0]  memAddr;
  logic [BCW-1:0] memBurstCount;
  logic [DW-1:0]  memWriteData;
  logic           memWaitRequest = 1'b0;

  burst_write_master #(
    .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .MAX_BURST(MB), .FIFO_DEPTH(FD), .REALIGN(1'b1)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .dataValid(dataValid), .dataReady(dataReady), .dataIn(dataIn),
    .memWrite(memWrite), .memAddr(memAddr), .memBurstCount(memBurstCount),
    .memWriteData(memWriteData), .memWaitRequest(memWaitRequest)
  );

  int nCmp = 0, nBad = 0, cycles = 0;
  int expAddr[$];
  int expRem[$];
  bit expFirst[$];
  int fifoModel = 0, pushSeq = 0, popSeq = 0, totalWords = 0;
  int beatsLeft = 0, beatIdx = 0, burstBase = 0;
  bit prevStall = 0, zeroSeen = 0, accepted = 0;
  logic [AW-1:0] pA;
  logic [BCW-1:0] pB;
  logic [DW-1:0] pD;
  int wMode = 0, dMode = 0;
  bit pendValid = 0;
  int pendAddr = 0, pendLen = 0;

  function automatic logic [DW-1:0] pat(input int n);
    return (DW'(n) * 32'h9E37_79B1) ^ 32'h0000_A5A5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "WDOG", "watchdog expired", cycles, 150000);
      finishRun();
    end
    // drive inputs for the coming edge
    cmdValid = pendValid;
    cmdAddr  = AW'(pendAddr);
    cmdLen   = LW'(pendLen);
    case (wMode)
      0:       memWaitRequest = 1'b0;
      1:       memWaitRequest = (($urandom % 2) == 1);
      default: memWaitRequest = (($urandom % 4) != 0);
    endcase
    dataValid = (dMode == 0) ? 1'b1 : (($urandom % 2) == 1);
    dataIn    = pat(pushSeq);

    // observe outputs (state-only, stable until next edge)
    if (zeroSeen) begin
      check(cmdReady === 1'b1 && memWrite === 1'b0, "R10", "zero length idle",
            {cmdReady, memWrite}, 2'b10);
      zeroSeen = 0;
    end
    check(cmdReady === (expAddr.size() == 0), "R2", "cmdReady vs open block",
          cmdReady, expAddr.size() == 0);
    check(dataReady === (fifoModel < FD), "R9", "dataReady vs buffered words",
          dataReady, fifoModel < FD);
    if (prevStall)
      check(memWrite === 1'b1 && memAddr === pA && memBurstCount === pB && memWriteData === pD,
            "R8", "held beat changed", memAddr, pA);
    if (beatsLeft > 0)
      check(memWrite === 1'b1, "R7", "gap inside burst", memWrite, 1);

    if (memWrite === 1'b1 && beatsLeft == 0) begin
      if (expAddr.size() == 0) begin
        check(1'b0, "R3", "write without open block", memAddr, 0);
      end else begin
        int a, r, room, e;
        a = expAddr[0];
        r = expRem[0];
        room = MB - (a % MB);
        e = (r < room) ? r : room;
        check(int'(memBurstCount) == e, (expFirst[0] && (a % MB) != 0) ? "R5" : "R6",
              "burst length", memBurstCount, e);
        check(memBurstCount >= 1 && int'(memBurstCount) <= MB, "R4", "burst count range",
              memBurstCount, MB);
        check(fifoModel >= int'(memBurstCount), "R7", "burst started short of data",
              fifoModel, memBurstCount);
        beatsLeft = int'(memBurstCount);
        beatIdx   = 0;
        burstBase = int'(memAddr);
      end
    end

    if (memWrite === 1'b1 && memWaitRequest == 1'b0 && beatsLeft > 0 && expAddr.size() > 0) begin
      check(int'(memAddr) == burstBase, "R4", "burst address not held", memAddr, burstBase);
      check(burstBase / BY + beatIdx == expAddr[0], "R3", "beat word address",
            burstBase / BY + beatIdx, expAddr[0]);
      check(memWriteData === pat(popSeq), "R3", "beat data", memWriteData, pat(popSeq));
      void'(expAddr.pop_front());
      void'(expRem.pop_front());
      void'(expFirst.pop_front());
      popSeq++;
      fifoModel--;
      beatsLeft--;
      beatIdx++;
    end

    if (dataValid && dataReady) begin
      fifoModel++;
      pushSeq++;
    end

    if (cmdValid && cmdReady) begin
      int words;
      accepted = 1;
      words = int'(cmdLen) / BY;
      if (words == 0) zeroSeen = 1;
      for (int i = 0; i < words; i++) begin
        expAddr.push_back(int'(cmdAddr) / BY + i);
        expRem.push_back(words - i);
        expFirst.push_back(i == 0);
      end
      totalWords += words;
    end

    prevStall = memWrite && memWaitRequest;
    pA = memAddr;
    pB = memBurstCount;
    pD = memWriteData;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    check(cmdReady === 1'b1 && dataReady === 1'b1 && memWrite === 1'b0, "R1",
          "reset outputs", {cmdReady, dataReady, memWrite}, 3'b110);
    rstN = 1'b1;
    @(negedge clk);
    // R1 after release
    check(cmdReady === 1'b1 && dataReady === 1'b1 && memWrite === 1'b0, "R1",
          "post reset outputs", {cmdReady, dataReady, memWrite}, 3'b110);

    for (int wm = 0; wm < 3; wm++) begin
      for (int dm = 0; dm < 2; dm++) begin
        wMode = wm;
        dMode = dm;
        for (int off = 0; off < 4; off++) begin
          for (int len = 0; len < 10; len++) begin
            pendValid = 1;
            pendAddr  = (64 + 16 * len + off) * BY;
            pendLen   = len * BY;
            accepted  = 0;
            do step(); while (!accepted);
          end
        end
      end
    end
    pendValid = 0;
    while (expAddr.size() != 0) step();
    step();
    check(popSeq == totalWords, "R3", "total beats", popSeq, totalWords);
    check(cmdReady === 1'b1 && memWrite === 1'b0, "R2", "idle after drain",
          {cmdReady, memWrite}, 2'b10);
    finishRun();
  end

endmodule